// File: doc/BRIEF.md
# Ethernet Receive Frame Decapsulator

This block sits behind a 4-bit media-independent receive interface and turns the nibble stream into whole frames on an 8-bit output stream. It hunts for the start-of-frame delimiter, throws away everything up to and including it, and pairs nibbles into bytes. While a frame arrives it runs a CRC-32 over the bytes and counts them. Every byte goes into a circular frame store. When carrier drops, the block settles the frame's fate. It can rewind the store to drop an errored frame, or cut off the frame check sequence and any padding. Otherwise it appends a 32-bit status word and releases the whole frame to the reader at once.

The output is a valid/ready stream. A data byte and a status byte are told apart by `out_status`, and `out_last` marks the final status byte of each frame. The reader may hold `out_ready` low for as long as it likes. The pending entry and its flags then stay put, and nothing is lost or repeated. Back-pressure cannot reach the line side, so a frame arriving into a nearly full store is truncated and flagged instead. Frames must be separated by the normal inter-frame gap of at least 24 nibble times, because the four status writes take place inside that gap.

Top module: `ethrx_decap`

## Requirements
- R1: Nibbles are ignored until the first low-nibble-first pair 0x5 then 0xD (byte 0xD5) is seen with `mii_dv` high. Neither the number of preamble bytes nor a stray leading nibble changes the output, and the first data byte out is the first byte after that pair.
- R2: Each two nibbles after the delimiter form one byte, with the first nibble as bits 3:0. An odd nibble left when `mii_dv` falls is discarded.
- R3: Each forwarded frame appears as its data entries (`out_status`=0, `out_last`=0), followed by exactly four status entries (`out_status`=1) carrying the status word least significant byte first. `out_last`=1 only on the fourth status entry.
- R4: Status bit 16 is set when the CRC-32 over all bytes after the delimiter (FCS included) does not leave the residue whose bit-reversed form is 0xC704DD7B.
- R5: Status bits 15:0 hold the number of bytes received after the delimiter, FCS included. Bit 18 is set when that count is below 64.
- R6: Status bit 17 is set when the byte count exceeds `cfg_max_len`.
- R7: Status bit 19 is set when `mii_er` was high on any nibble of the frame after the delimiter.
- R8: With `cfg_strip`=0 every received byte is forwarded. With `cfg_strip`=1 the last 4 bytes are removed. If the field in bytes 12 (high) and 13 (low) is at most 1500 and 14 plus that value is below the remaining count, only the first 14 plus that value bytes are kept.
- R9: With `cfg_drop_err`=1, a frame with any of status bits 16 to 20 set produces no output entries at all, while good frames are forwarded unchanged. With `cfg_drop_err`=0 errored frames are forwarded with their status.
- R10: `out_valid` is low after reset. While `out_valid`=1 and `out_ready`=0, `out_valid` and the entry stay stable, and every entry is delivered exactly once.
- R11: Data bytes are stored only while fewer than DEPTH-4 entries are occupied. Bytes past that point are lost and status bit 20 is set, and the status word is always delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one nibble per cycle while `mii_dv` is high |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_dv | input | 1 | Receive data valid |
| mii_d | input | 4 | Receive nibble |
| mii_er | input | 1 | Receive error indication |
| cfg_strip | input | 1 | Remove FCS and length-indicated padding |
| cfg_drop_err | input | 1 | Discard frames with any error flag |
| cfg_max_len | input | LEN_W | Largest accepted byte count |
| out_valid | output | 1 | Output entry available |
| out_ready | input | 1 | Reader accepts the entry |
| out_data | output | 8 | Data byte or status byte |
| out_status | output | 1 | Entry is a status byte |
| out_last | output | 1 | Final status byte of the frame |

## Verification
The assertions check on every cycle that assembled bytes never come on back-to-back cycles, and that the committed store never holds more than its depth. They also check that a stalled output entry stays frozen, that `out_valid` only falls after a handshake, and that `out_last` is only ever raised on a status entry. Whether the right bytes leave is a matter for the bench scenarios alone. That covers delimiter hunting over varied preambles, nibble order, pad and FCS trimming, the value of each status flag, the complete absence of dropped frames, and truncation when the store fills behind a stalled reader.

// File: rtl/ethrx_pkg.sv
package ethrx_pkg;
  localparam logic [7:0]  SFD_BYTE     = 8'hD5;
  localparam logic [31:0] CRC_POLY_R   = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;  // bit-reversed 0xC704DD7B
  localparam int          RUNT_BYTES   = 64;
  localparam int          LEN_TYPE_MAX = 1500;
  localparam int          STAT_BYTES   = 4;

  typedef struct packed {
    logic       status;
    logic       last;
    logic [7:0] data;
  } ring_word_t;

  typedef enum logic [1:0] {FR_IDLE, FR_RECV, FR_STAT} fr_state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/ethrx_nibble.sv
module ethrx_nibble
  import ethrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dv,
  input  logic [3:0] d,
  input  logic       er,
  output logic       b_valid,
  output logic [7:0] b_data,
  output logic       sfd,
  output logic       eof,
  output logic       er_seen
);
  logic       in_frm, have_prev, phase;
  logic [3:0] prev, lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frm <= 1'b0; have_prev <= 1'b0; phase <= 1'b0;
      prev <= '0; lo <= '0; b_valid <= 1'b0; b_data <= '0;
      sfd <= 1'b0; eof <= 1'b0; er_seen <= 1'b0;
    end else begin
      b_valid <= 1'b0;
      sfd     <= 1'b0;
      eof     <= 1'b0;
      if (!dv) begin
        eof       <= in_frm;
        in_frm    <= 1'b0;
        have_prev <= 1'b0;
      end else if (!in_frm) begin
        if (have_prev && prev == SFD_BYTE[3:0] && d == SFD_BYTE[7:4]) begin
          in_frm  <= 1'b1;
          sfd     <= 1'b1;
          phase   <= 1'b0;
          er_seen <= 1'b0;
        end
        prev      <= d;
        have_prev <= 1'b1;
      end else begin
        if (er) er_seen <= 1'b1;
        phase <= ~phase;
        if (!phase) lo <= d;
        else begin
          b_valid <= 1'b1;
          b_data  <= {d, lo};
        end
      end
    end
  end

  assert_byte_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |=> !b_valid);
endmodule

// File: rtl/ethrx_crc.sv
module ethrx_crc
  import ethrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= '1;
    else if (clr) crc_q <= '1;
    else if (en)  crc_q <= crc_step(crc_q, din);
  end
endmodule

// File: rtl/ethrx_ring.sv
module ethrx_ring
  import ethrx_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [AW-1:0] waddr,
  input  ring_word_t wdata,
  input  logic [AW:0] commit,
  output logic [AW:0] rd_ptr,
  output logic       out_valid,
  input  logic       out_ready,
  output ring_word_t out_word
);
  ring_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= '0;
    else if (out_valid && out_ready) rd_ptr <= rd_ptr + 1'b1;
  end

  assign out_valid = (rd_ptr != commit);
  assign out_word  = mem[rd_ptr[AW-1:0]];

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit - rd_ptr) <= (AW+1)'(DEPTH));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
endmodule

// File: rtl/ethrx_decap.sv
module ethrx_decap
  import ethrx_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mii_dv,
  input  logic [3:0]       mii_d,
  input  logic             mii_er,
  input  logic             cfg_strip,
  input  logic             cfg_drop_err,
  input  logic [LEN_W-1:0] cfg_max_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_status,
  output logic             out_last
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] ROOM_LIM = (AW+1)'(DEPTH - STAT_BYTES);

  logic        b_valid, sfd, eof, er_seen;
  logic [7:0]  b_data;
  logic [31:0] crc_q;
  logic [AW:0] rd_ptr, wr, commit, stored;
  logic [15:0] cnt, ltype;
  logic [31:0] stat_q, status_w;
  logic [1:0]  sidx;
  fr_state_t   st;
  logic        we, room;
  ring_word_t  wdata, out_word;

  ethrx_nibble u_nib (
    .clk, .rst_n, .dv(mii_dv), .d(mii_d), .er(mii_er),
    .b_valid, .b_data, .sfd, .eof, .er_seen
  );

  ethrx_crc u_crc (
    .clk, .rst_n, .clr(sfd), .en(b_valid), .din(b_data), .crc_q
  );

  ethrx_ring #(.DEPTH(DEPTH)) u_ring (
    .clk, .rst_n, .we, .waddr(wr[AW-1:0]), .wdata, .commit, .rd_ptr,
    .out_valid, .out_ready, .out_word
  );

  // end-of-frame verdict
  logic [15:0] data_n, strip_n, want, stored16, kept16;
  logic [16:0] pad_lim;
  logic        crc_bad, giant, runt, ovr, any_err;

  always_comb begin
    stored16 = 16'(stored);
    data_n   = (cnt >= 16'd4) ? cnt - 16'd4 : 16'd0;
    pad_lim  = {1'b0, ltype} + 17'd14;
    strip_n  = (ltype <= 16'(LEN_TYPE_MAX) && pad_lim < {1'b0, data_n}) ? pad_lim[15:0] : data_n;
    want     = cfg_strip ? strip_n : cnt;
    kept16   = (want < stored16) ? want : stored16;
    crc_bad  = (crc_q != CRC_RESIDUE);
    giant    = (cnt > 16'(cfg_max_len));
    runt     = (cnt < 16'(RUNT_BYTES));
    ovr      = (stored16 < cnt);
    any_err  = crc_bad | giant | runt | ovr | er_seen;
    status_w = {11'd0, ovr, er_seen, runt, giant, crc_bad, cnt};
  end

  assign room = ((wr - rd_ptr) < ROOM_LIM);
  assign we   = (st == FR_RECV && b_valid && room) || (st == FR_STAT);

  always_comb begin
    if (st == FR_STAT) begin
      wdata.status = 1'b1;
      wdata.last   = (sidx == 2'd3);
      wdata.data   = stat_q[8*sidx +: 8];
    end else begin
      wdata.status = 1'b0;
      wdata.last   = 1'b0;
      wdata.data   = b_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FR_IDLE; wr <= '0; commit <= '0; stored <= '0;
      cnt <= '0; ltype <= '0; stat_q <= '0; sidx <= '0;
    end else begin
      case (st)
        FR_IDLE: if (sfd) begin
          st <= FR_RECV; cnt <= '0; stored <= '0; ltype <= '0; wr <= commit;
        end
        FR_RECV: begin
          if (b_valid) begin
            if (cnt != 16'hFFFF) cnt <= cnt + 16'd1;
            if (cnt == 16'd12) ltype[15:8] <= b_data;
            if (cnt == 16'd13) ltype[7:0]  <= b_data;
            if (room) begin
              wr     <= wr + 1'b1;
              stored <= stored + 1'b1;
            end
          end else if (eof) begin
            if (cfg_drop_err && any_err) begin
              wr <= commit;
              st <= FR_IDLE;
            end else begin
              wr     <= commit + kept16[AW:0];
              stat_q <= status_w;
              sidx   <= '0;
              st     <= FR_STAT;
            end
          end
        end
        FR_STAT: begin
          wr   <= wr + 1'b1;
          sidx <= sidx + 2'd1;
          if (sidx == 2'd3) begin
            commit <= wr + 1'b1;
            st     <= FR_IDLE;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  assign out_data   = out_word.data;
  assign out_status = out_word.status;
  assign out_last   = out_word.last;

  assert_last_is_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> out_status);
endmodule

// File: tb/tb_ethrx_decap.sv
module tb_ethrx_decap;
  localparam int DEPTH  = 128;
  localparam int MAXLEN = 100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, mii_dv, mii_er, cfg_strip, cfg_drop_err, out_ready;
  logic [3:0] mii_d;
  logic [13:0] cfg_max_len;
  logic       out_valid, out_status, out_last;
  logic [7:0] out_data;

  ethrx_decap #(.DEPTH(DEPTH)) dut (
    .clk, .rst_n, .mii_dv, .mii_d, .mii_er, .cfg_strip, .cfg_drop_err,
    .cfg_max_len, .out_valid, .out_ready, .out_data, .out_status, .out_last
  );

  int n_chk = 0, n_bad = 0;
  int rdy_mode = 0, cyc = 0, ncap = 0;
  logic [9:0] cap [0:511];
  logic [7:0] fr [0:255];
  logic       prev_stall = 1'b0;
  logic [9:0] prev_word = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reader: set ready at negedge, then sample what the next edge will accept
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
    #1;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && ({out_status, out_last, out_data} == prev_word), "R10",
              {21'd0, out_valid, out_status, out_last, out_data}, {22'd1, prev_word}, "stalled entry");
      prev_stall = out_valid && !out_ready;
      prev_word  = {out_status, out_last, out_data};
      if (out_valid && out_ready) begin
        if (ncap < 512) cap[ncap] = {out_status, out_last, out_data};
        ncap++;
      end
    end
  end

  task automatic nib(input logic [3:0] v, input logic e);
    @(negedge clk);
    mii_dv = 1'b1; mii_d = v; mii_er = e;
  endtask

  task automatic idle(input int k);
    repeat (k) begin
      @(negedge clk);
      mii_dv = 1'b0; mii_d = 4'h0; mii_er = 1'b0;
    end
  endtask

  task automatic run_frame(input int n, input int tf, input bit bad, input int erp,
                           input int pre, input bit junk, input bit odd, input bit strip,
                           input bit drop, input int mode, input string tag);
    logic [31:0] c, fcs, sw;
    int tot, stored, kept, exp_n;
    bit err;
    logic [9:0] ew;
    for (int i = 0; i < n; i++) fr[i] = 8'(i * 37 + n + 3);
    fr[12] = tf[15:8];
    fr[13] = tf[7:0];
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, fr[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    fcs = ~c;
    for (int i = 0; i < 4; i++) fr[n + i] = fcs[8*i +: 8];
    if (bad) fr[n] = fr[n] ^ 8'h01;
    cfg_strip = strip; cfg_drop_err = drop; ncap = 0; rdy_mode = mode;
    if (junk) nib(4'hA, 1'b0);
    for (int p = 0; p < pre; p++) begin nib(4'h5, 1'b0); nib(4'h5, 1'b0); end
    nib(4'h5, 1'b0); nib(4'hD, 1'b0);
    for (int i = 0; i < n + 4; i++) begin
      nib(fr[i][3:0], i == erp);
      nib(fr[i][7:4], 1'b0);
    end
    if (odd) nib(4'h7, 1'b0);
    idle(4);
    rdy_mode = 0;
    idle(170);
    // expected result from the requirements
    tot    = n + 4;
    stored = (tot < DEPTH - 4) ? tot : DEPTH - 4;
    sw = {11'd0, 1'(stored < tot), 1'(erp >= 0), 1'(tot < 64), 1'(tot > MAXLEN), bad, 16'(tot)};
    err = (sw[20:16] != 5'd0);
    if (drop && err) begin
      kept = 0; exp_n = 0;
    end else begin
      if (strip) kept = (tf <= 1500 && 14 + tf < n) ? 14 + tf : n;
      else       kept = tot;
      if (kept > stored) kept = stored;
      exp_n = kept + 4;
    end
    check(ncap == exp_n, tag, 32'(ncap), 32'(exp_n), "entry count");
    for (int i = 0; i < exp_n && i < ncap; i++) begin
      if (i < kept) ew = {2'b00, fr[i]};
      else          ew = {1'b1, 1'(i == kept + 3), sw[8*(i-kept) +: 8]};
      check(cap[i] == ew, tag, 32'(cap[i]), 32'(ew), $sformatf("entry %0d of n=%0d", i, n));
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n, tf, erp;
    bit bad;
    string tag;
    rst_n = 1'b0; mii_dv = 1'b0; mii_d = 4'h0; mii_er = 1'b0;
    cfg_strip = 1'b0; cfg_drop_err = 1'b0; cfg_max_len = 14'(MAXLEN); out_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R10", 32'(out_valid), 0, "valid in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", 32'(out_valid), 0, "valid after reset");

    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 10; c++) begin
          n = 60; tf = 16'h0800; bad = 0; erp = -1; tag = "R3";
          case (c)
            0: begin n = 16; tag = "R5"; end          // runt
            1: begin n = 59; tag = "R5"; end          // 63 bytes, runt
            2: begin n = 60; tag = "R5"; end          // 64 bytes, not runt
            3: begin n = 46; tf = 30; tag = "R8"; end // padding trimmed
            4: begin n = 46; tf = 32; tag = "R8"; end // boundary, nothing trimmed
            5: begin n = 70; tag = "R1"; end          // preamble variants
            6: begin n = 80; bad = 1; tag = "R4"; end // CRC error
            7: begin n = 50; erp = 20; tag = "R7"; end
            8: begin n = 96; tag = "R6"; end          // exactly max length
            default: begin n = 97; tag = "R6"; end    // one over max length
          endcase
          run_frame(n, tf, bad, erp, 1 + (c % 7), 1'(c % 2), 1'b0, 1'(s), 1'(d), 0,
                    $sformatf("%s/%s", tag, d ? "R9" : "R3"));
        end

    run_frame(64, 16'h0800, 0, -1, 6, 0, 1, 0, 0, 0, "R2");   // trailing odd nibble
    run_frame(64, 16'h0806, 0, -1, 7, 1, 0, 1, 0, 1, "R10");  // reader back-pressure
    run_frame(60, 16'h0800, 0, -1, 3, 0, 0, 0, 0, 1, "R10");
    run_frame(196, 16'h0800, 0, -1, 7, 0, 0, 0, 0, 2, "R11"); // store fills while stalled
    run_frame(196, 16'h0800, 0, -1, 7, 0, 0, 1, 0, 2, "R11");
    run_frame(196, 16'h0800, 0, -1, 7, 0, 0, 0, 1, 2, "R11/R9");
    run_frame(60, 16'h0800, 0, -1, 7, 0, 0, 0, 1, 0, "R9");

    summary();
    $finish;
  end
endmodule